// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst in a synchronous static memory. A load strobe captures a full external base address. Its upper bits then stay fixed until the next load. The two lowest bits come from a two-bit beat counter, combined with the captured start bits in one of two orders. With the order select high, each beat's low bits are the start bits XORed with the beat count. With the order select low, the low bits are the start bits plus the beat count, wrapping modulo four.

An advance strobe moves the counter one beat forward. When advance is low, the current address is held as a wait cycle. After the fourth beat, one more advance returns the address to the loaded start address. A load always restarts the sequence from the new base, even in the middle of a burst, and a load wins over an advance on the same edge. A flag marks the fourth beat. Chip-select decoding does not gate the advance path; that logic sits outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `word_addr` is 0 and `last_beat` is 0.
- R2: One cycle after an edge with `load` high, `word_addr` equals the `base_addr` presented at that edge and `last_beat` is 0.
- R3: Bits [14:2] of `word_addr` change only on a load; advances and wait cycles leave them at the loaded base.
- R4: With `ilv_order` = 1, beat k (k = 0..3, the count of advances since the load) has low bits equal to start[1:0] XOR k. For a start of 01 the sequence is 01, 00, 11, 10.
- R5: With `ilv_order` = 0, beat k has low bits equal to (start[1:0] + k) mod 4. For a start of 10 the sequence is 10, 11, 00, 01.
- R6: An advance from the fourth beat returns `word_addr` to the loaded start address, in either order.
- R7: An edge with `advance` low and `load` low holds `word_addr` and `last_beat` unchanged.
- R8: A load in the middle of a burst restarts the beat count at 0 from the new base.
- R9: When `load` and `advance` are both high on one edge, the load takes effect and the advance is ignored.
- R10: `last_beat` is 1 exactly when the beat count is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 15 | External start address, captured on load |
| load | input | 1 | Captures base_addr and restarts the burst |
| advance | input | 1 | Moves to the next beat; low inserts a wait cycle |
| ilv_order | input | 1 | Burst order: 1 interleaved (XOR), 0 linear (wrapping add); treated as static |
| word_addr | output | 15 | Current burst word address |
| last_beat | output | 1 | High on the fourth beat of the sequence |

## Verification
Load and advance can fall on the same clock edge. The bench provokes this by raising both strobes in the middle of a running burst, with a new base on the address input. It then checks that the next address is exactly the new base with `last_beat` low, rather than the old burst's next beat or the new base's second beat. A following advance checks that the counter restarted at beat one of the new base.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              load,
  input  logic              advance,
  input  logic              ilv_order,
  output logic [ADDR_W-1:0] word_addr,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      hi_q    <= base_addr[ADDR_W-1:BEAT_W];
      start_q <= base_addr[BEAT_W-1:0];
      beat_q  <= '0;
    end else if (advance) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low_bits  = ilv_order ? (start_q ^ beat_q) : (start_q + beat_q);
  assign word_addr = {hi_q, low_bits};
  assign last_beat = &beat_q;
endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic              load,
  input logic              advance,
  input logic              ilv_order,
  input logic [ADDR_W-1:0] word_addr,
  input logic              last_beat
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (word_addr == '0 && !last_beat));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_addr == $past(base_addr) && !last_beat));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_addr[ADDR_W-1:2]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && !ilv_order) |=>
      (ilv_order || word_addr[1:0] == $past(word_addr[1:0]) + 2'd1));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=>
      ((!$stable(ilv_order)) || ($stable(word_addr) && $stable(last_beat))));

  // R10
  last_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && advance && !load) |=> !last_beat);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .load(load),
  .advance(advance), .ilv_order(ilv_order), .word_addr(word_addr),
  .last_beat(last_beat)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] base_addr;
  logic        load, advance, ilv_order;
  logic [14:0] word_addr;
  logic        last_beat;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .load(load),
    .advance(advance), .ilv_order(ilv_order), .word_addr(word_addr),
    .last_beat(last_beat)
  );

  function automatic logic [14:0] expect_addr(logic [14:0] b, int k, logic ilv);
    logic [1:0] kk;
    kk = k[1:0];
    return {b[14:2], ilv ? (b[1:0] ^ kk) : (b[1:0] + kk)};
  endfunction

  task automatic chk(string req, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(logic [14:0] b);
    base_addr = b; load = 1'b1; advance = 1'b0;
    step();
    load = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load = 1'b1; advance = 1'b1; ilv_order = 1'b1;
    base_addr = 15'h7fff;
    step(); step();
    chk("R1 addr in reset", word_addr, 15'h0);
    chk("R1 last in reset", {14'd0, last_beat}, 15'h0);
    load = 1'b0; advance = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 addr after reset", word_addr, 15'h0);
    chk("R1 last after reset", {14'd0, last_beat}, 15'h0);
  endtask

  task automatic t_burst(logic ilv, logic [14:0] b);
    string tag;
    tag = ilv ? "R4" : "R5";
    ilv_order = ilv;
    do_load(b);
    chk("R2 load capture", word_addr, b);
    chk("R2 last after load", {14'd0, last_beat}, 15'h0);
    advance = 1'b1;
    for (int k = 1; k < 4; k++) begin
      step();
      chk(tag, word_addr, expect_addr(b, k, ilv));
      chk("R3 upper bits", {2'b00, word_addr[14:2]}, {2'b00, b[14:2]});
      chk("R10 last beat", {14'd0, last_beat}, {14'd0, (k == 3)});
    end
    step();
    chk("R6 wrap to start", word_addr, b);
    chk("R10 last cleared on wrap", {14'd0, last_beat}, 15'h0);
    advance = 1'b0;
  endtask

  task automatic t_wait();
    logic [14:0] b;
    b = 15'h2a57;
    ilv_order = 1'b0;
    do_load(b);
    advance = 1'b1;
    step(); step(); step();
    chk("R7 reach beat 3", word_addr, expect_addr(b, 3, 1'b0));
    advance = 1'b0;
    step(); step();
    chk("R7 wait holds addr", word_addr, expect_addr(b, 3, 1'b0));
    chk("R7 wait holds last", {14'd0, last_beat}, 15'h1);
    advance = 1'b1;
    step();
    chk("R7 resume after wait", word_addr, b);
    advance = 1'b0;
  endtask

  task automatic t_restart();
    logic [14:0] b1, b2;
    b1 = 15'h1235; b2 = 15'h4cd2;
    ilv_order = 1'b1;
    do_load(b1);
    advance = 1'b1;
    step();
    advance = 1'b0;
    do_load(b2);
    chk("R8 restart base", word_addr, b2);
    advance = 1'b1;
    step();
    chk("R8 restart beat 1", word_addr, expect_addr(b2, 1, 1'b1));
    advance = 1'b0;
  endtask

  task automatic t_collide();
    logic [14:0] b1, b3;
    b1 = 15'h0f01; b3 = 15'h7a03;
    ilv_order = 1'b0;
    do_load(b1);
    advance = 1'b1;
    step(); step();
    base_addr = b3; load = 1'b1;
    step();
    load = 1'b0;
    chk("R9 load wins", word_addr, b3);
    chk("R9 last low", {14'd0, last_beat}, 15'h0);
    step();
    chk("R9 next beat from new base", word_addr, expect_addr(b3, 1, 1'b0));
    chk("R3 upper bits after collide", {2'b00, word_addr[14:2]}, {2'b00, b3[14:2]});
    advance = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(1'b1, 15'h5a01);
    t_burst(1'b0, 15'h33c2);
    t_burst(1'b1, 15'h0003);
    t_burst(1'b0, 15'h7fff);
    t_wait();
    t_restart();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule